// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous logic read and write an asynchronous 32K x 8 static RAM one access at a time. A requester presents a read or write with a valid signal. The controller accepts it when its ready signal is high. It then sequences the active-low chip-select, read-strobe and write-strobe pins of the memory, and it steers an 8-bit bidirectional data bus through a separate drive-out word and tri-state enable. Read results come back on a data word that is qualified by a one-cycle valid pulse.

Every phase of an access is a whole number of clock cycles. The counts are parameters, so an integrator derives them from the clock period and the speed grade of the memory. `READ_WAIT` is the number of cycles the read strobe is held low before the data is sampled. `WR_PULSE` is the width of the write-strobe pulse. `DATA_HOLD` is the number of cycles the write data is still driven after the strobe rises. `TURNAROUND` is the number of dead cycles after every access. The write strobe always falls and rises inside a chip-select window. The read strobe is never low while the controller drives the bus, and it is never low while the write strobe is low.

The state machine has eight states:
- **IDLE**: `req_ready` is high. A valid request moves to RD_SETUP or WR_SETUP according to `req_write`.
- **RD_SETUP**: lasts one cycle, then moves to RD_WAIT.
- **RD_WAIT**: lasts `READ_WAIT` cycles, then moves to RD_CAPTURE.
- **RD_CAPTURE**: lasts one cycle with the valid pulse, then moves to TURNAROUND.
- **WR_SETUP**: lasts one cycle, then moves to WR_PULSE.
- **WR_PULSE**: lasts `WR_PULSE` cycles, then moves to WR_HOLD.
- **WR_HOLD**: lasts `DATA_HOLD` cycles, then moves to TURNAROUND.
- **TURNAROUND**: lasts `TURNAROUND` cycles, then moves back to IDLE.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is applied and whenever the controller is idle, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted on the rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access completes. A request presented while `req_ready` is 0 changes neither the memory nor the access in progress.
- R3: The address and write data are registered when the request is accepted. `mem_addr` equals the accepted address in every cycle that `mem_ce_n` is 0.
- R4: A read holds `mem_ce_n` at 0 with `mem_oe_n` at 1 for one cycle, then holds `mem_oe_n` at 0 for `READ_WAIT` cycles. `mem_dq_i` is sampled at the end of the last of those cycles. `rsp_valid` is a single-cycle pulse in cycle 2+`READ_WAIT` after the accepting edge, with that sample on `rsp_rdata`. A write produces no `rsp_valid`.
- R5: A write first drives the data with `mem_ce_n` at 0 and `mem_we_n` at 1 for one cycle. It then holds `mem_we_n` at 0 for exactly `WR_PULSE` cycles. After that it keeps `mem_dq_oe` at 1 with `mem_we_n` at 1 for `DATA_HOLD` cycles.
- R6: `mem_oe_n` is 0 only when `mem_we_n` is 1 and `mem_dq_oe` is 0, so the controller and the memory never drive the bus at the same time.
- R7: `mem_we_n` is 0 only while `mem_ce_n` is 0.
- R8: Every access ends with `TURNAROUND` cycles in which `mem_ce_n` is 1 and `mem_dq_oe` is 0. `req_ready` is therefore 0 for 2+`READ_WAIT`+`TURNAROUND` cycles on a read and for 1+`WR_PULSE`+`DATA_HOLD`+`TURNAROUND` cycles on a write.
- R9: A read returns the byte most recently written to the same address.
- R10: `mem_dq_o` does not change while `mem_we_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Word address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_rdata | output | DATA_W (8) | Byte read |
| rsp_valid | output | 1 | One-cycle qualifier for `rsp_rdata` |
| mem_addr | output | ADDR_W (15) | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | DATA_W (8) | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W (8) | Data bus as seen from the pins |

## Verification
The bench uses an 8-bit address configuration and a behavioural memory. That memory drives the bus only on a legal read, stores a byte on the rising edge of the write strobe, and counts every overlap of its own drive with the controller's drive.

The bench first writes every address with an arithmetic pattern and reads every address back. It then overwrites all of them with a second pattern while hammering the request port during each busy window. The second full read-back separates a controller that honours late requests from one that ignores them.

A final run of pseudo-random mixed reads and writes against a scoreboard exercises back-to-back write-then-read turnarounds. The latency and busy-length counts of each access show whether any phase is a cycle short or long.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURNAROUND
    } ctl_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_req,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              sample_rd,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (capture_req) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (sample_rd) begin
            rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int READ_WAIT  = 2,
    parameter int WR_PULSE   = 1,
    parameter int DATA_HOLD  = 1,
    parameter int TURNAROUND = 1,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             sample_rd,
    output logic             ready,
    output logic             rsp_pulse,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_drive
);

    localparam logic [CNT_W-1:0] RW_LOAD = CNT_W'(READ_WAIT - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] DH_LOAD = CNT_W'(DATA_HOLD - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TURNAROUND - 1);

    ctl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
            end
            ST_RD_SETUP: begin
                state_d  = ST_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = RW_LOAD;
            end
            ST_RD_WAIT: begin
                if (tmr_expired) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                state_d  = ST_TURNAROUND;
                tmr_load = 1'b1;
                tmr_val  = TA_LOAD;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = DH_LOAD;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) begin
                    state_d  = ST_TURNAROUND;
                    tmr_load = 1'b1;
                    tmr_val  = TA_LOAD;
                end
            end
            ST_TURNAROUND: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // pin and handshake decode
    always_comb begin
        ready     = 1'b0;
        rsp_pulse = 1'b0;
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        dq_drive  = 1'b0;
        unique case (state_q)
            ST_IDLE:       ready = 1'b1;
            ST_RD_SETUP:   ce_n = 1'b0;
            ST_RD_WAIT:    begin ce_n = 1'b0; oe_n = 1'b0; end
            ST_RD_CAPTURE: rsp_pulse = 1'b1;
            ST_WR_SETUP:   begin ce_n = 1'b0; dq_drive = 1'b1; end
            ST_WR_PULSE:   begin ce_n = 1'b0; we_n = 1'b0; dq_drive = 1'b1; end
            ST_WR_HOLD:    begin ce_n = 1'b0; dq_drive = 1'b1; end
            ST_TURNAROUND: ;
            default:       ;
        endcase
    end

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign sample_rd = (state_q == ST_RD_WAIT) && tmr_expired;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int READ_WAIT  = 2,
    parameter int WR_PULSE   = 1,
    parameter int DATA_HOLD  = 1,
    parameter int TURNAROUND = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int MAX_LEN = max_of4(READ_WAIT, WR_PULSE, DATA_HOLD, TURNAROUND);
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic             tmr_load, tmr_expired, accept, sample_rd;
    logic [CNT_W-1:0] tmr_val;

    sram_ctl_fsm #(
        .READ_WAIT (READ_WAIT),
        .WR_PULSE  (WR_PULSE),
        .DATA_HOLD (DATA_HOLD),
        .TURNAROUND(TURNAROUND),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .sample_rd  (sample_rd),
        .ready      (req_ready),
        .rsp_pulse  (rsp_valid),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_drive   (mem_dq_oe)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_req(accept),
        .addr_in    (req_addr),
        .wdata_in   (req_wdata),
        .sample_rd  (sample_rd),
        .bus_in     (mem_dq_i),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_o),
        .rdata_q    (rsp_rdata)
    );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid)); // R1

    AST_NO_READY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R3

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n)); // R5

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R6

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R7

    AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_dq_o)); // R10

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int RW = 2;
    localparam int WP = 1;
    localparam int DH = 1;
    localparam int TA = 1;
    localparam int DEPTH = 1 << AW;
    localparam int RD_LAT  = 2 + RW;
    localparam int RD_BUSY = 2 + RW + TA;
    localparam int WR_BUSY = 1 + WP + DH + TA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    always #4 clk = ~clk;

    sram_bus_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .READ_WAIT(RW),
        .WR_PULSE(WP), .DATA_HOLD(DH), .TURNAROUND(TA)
    ) u_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // behavioural memory
    logic [DW-1:0] model_mem [DEPTH];
    logic          model_drv;
    assign model_drv = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
    assign mem_dq_i  = model_drv ? model_mem[mem_addr] : '0;

    initial for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;

    always @(posedge mem_we_n) begin
        if (rst_n && mem_ce_n === 1'b0 && mem_dq_oe === 1'b1)
            model_mem[mem_addr] = mem_dq_o;
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [AW-1:0] acc_addr = '0;

    // protocol monitors
    int v_contend = 0, v_we_ce = 0, v_addr = 0, v_pulse = 0, v_hold = 0, v_setup = 0, v_wdata = 0;
    int wlow = 0;
    logic prev_we_n = 1'b1, prev_dq_oe = 1'b0;
    logic [DW-1:0] prev_dq_o = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((model_drv && mem_dq_oe) || (!mem_oe_n && (mem_dq_oe || !mem_we_n))) v_contend++; // R6
            if (!mem_we_n && mem_ce_n) v_we_ce++;                                               // R7
            if (!mem_ce_n && mem_addr !== acc_addr) v_addr++;                                   // R3
            if (!mem_we_n) begin
                if (prev_we_n && !(prev_dq_oe)) v_setup++;                                      // R5
                if (!prev_we_n && mem_dq_o !== prev_dq_o) v_wdata++;                            // R10
                wlow++;
            end else if (wlow != 0) begin
                if (wlow != WP) v_pulse++;                                                      // R5
                if (!mem_dq_oe) v_hold++;                                                       // R5
                wlow = 0;
            end
            prev_we_n  = mem_we_n;
            prev_dq_oe = mem_dq_oe;
            prev_dq_o  = mem_dq_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit poke, output logic [DW-1:0] rd,
                          output int busy, output int lat, output int nval);
        @(negedge clk);
        acc_addr  = a;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        busy = 0; lat = 0; nval = 0; rd = '0;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (rsp_valid) begin lat = k; rd = rsp_rdata; nval++; end
            if (req_ready) begin req_valid = 1'b0; break; end
            busy++;
            if (poke) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = a - 1'b1; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
        end
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'((a * 37 + 11) % 256);
    endfunction

    function automatic logic [DW-1:0] pat2(input int a);
        return DW'(255 - ((a * 13 + 5) % 256));
    endfunction

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit poke);
        logic [DW-1:0] rd;
        int busy, lat, nval;
        access(1'b1, AW'(a), d, poke, rd, busy, lat, nval);
        chk(busy == WR_BUSY, "R8 write busy length", busy, WR_BUSY);
        chk(nval == 0, "R4 no response on write", nval, 0);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp);
        logic [DW-1:0] rd;
        int busy, lat, nval;
        access(1'b0, AW'(a), '0, 1'b0, rd, busy, lat, nval);
        chk(rd == exp, "R9 read data", int'(rd), int'(exp));
        chk(lat == RD_LAT, "R4 read latency", lat, RD_LAT);
        chk(nval == 1, "R4 single valid pulse", nval, 1);
        chk(busy == RD_BUSY, "R8 read busy length", busy, RD_BUSY);
    endtask

    logic [DW-1:0] sb [DEPTH];

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
            "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 idle after reset", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);

        // sweep 1: write every address, read every address
        for (int a = 0; a < DEPTH; a++) begin do_write(a, pat1(a), 1'b0); sb[a] = pat1(a); end
        for (int a = 0; a < DEPTH; a++) do_read(a, sb[a]);

        // sweep 2: overwrite with late requests hammered during busy (R2)
        for (int a = 0; a < DEPTH; a++) begin do_write(a, pat2(a), 1'b1); sb[a] = pat2(a); end
        for (int a = 0; a < DEPTH; a++) do_read(a, sb[a]); // R2: pokes must leave no trace

        // pseudo-random mixed traffic with scoreboard
        begin
            int unsigned lcg = 32'h1234_5678;
            for (int i = 0; i < 600; i++) begin
                int a;
                logic [DW-1:0] d;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                a = int'((lcg >> 8) % DEPTH);
                d = DW'(lcg >> 20);
                if (lcg[3]) begin
                    do_write(a, d, 1'b0);
                    sb[a] = d;
                    do_read(a, d); // write immediately followed by read
                end else begin
                    do_read(a, sb[a]);
                end
            end
        end

        @(negedge clk);
        chk(v_contend == 0, "R6 bus contention cycles", v_contend, 0);
        chk(v_we_ce == 0, "R7 write strobe outside chip select", v_we_ce, 0);
        chk(v_addr == 0, "R3 address changed while selected", v_addr, 0);
        chk(v_pulse == 0, "R5 write pulse width", v_pulse, 0);
        chk(v_hold == 0, "R5 data hold after strobe", v_hold, 0);
        chk(v_setup == 0, "R5 data setup before strobe", v_setup, 0);
        chk(v_wdata == 0, "R10 data moved under strobe", v_wdata, 0);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle at end", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule